// File: doc/BRIEF.md
# Two-Word Control Port Decoder

This block decodes the 16-bit words a host writes to the control port of a video controller. A word is decoded in one of two ways. When no command is half-finished, a word whose top two bits read `10` writes one byte into a small register file. Any other word opens a two-word command: it loads the low address bits and the low command-code bits, then marks the command as pending. The next accepted word closes the command. It supplies the upper address bits and the upper command-code bits.

Closing a command can request a DMA. The request needs command-code bit 5 and the DMA-enable mode bit. The source-mode bits of the source-high register then decide what happens. Either a transfer launches at once, with its command code latched, or a fill is only armed and waits for a later data-port write. While a DMA runs, every control write is refused and reported. A data-port write or a status read abandons a half-finished command.

Top module: `ctlport_decoder`

## Requirements
- R1: A control write with `dma_busy` high changes no register, address, command code or pending flag, and starts or arms nothing.
- R2: With no command pending, an accepted word with bits 15:14 = `10` writes bits 7:0 into register number bits 12:8. It leaves the pending flag clear.
- R3: A register write whose number is NREG or above changes no register.
- R4: With no command pending, an accepted word whose bits 15:14 are not `10` loads address 13:0 from word 13:0 and command code 1:0 from word 15:14. It also sets the pending flag.
- R5: An accepted word while pending loads address 15:14 from word 1:0 and command code 5:2 from word 7:4. It keeps the other bits and clears the pending flag.
- R6: A DMA is requested only on closing a command with command-code bit 5 set and bit 4 of register 1 (DMA enable) set.
- R7: On a request where bits 7:6 of register 23 (source high) are not `10`, `dma_start` pulses for one cycle. `dma_cmd` latches the new command code, and `dma_copy` equals source-high bit 7.
- R8: On a request where source-high bits 7:6 are `10`, `fill_arm` pulses for one cycle and `dma_start` stays low.
- R9: `pend_clear` without an accepted write in the same cycle clears the pending flag.
- R10: `wr_reject` pulses for one cycle after each control write refused for `dma_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Control word presented this cycle |
| wr_data | input | 16 | Control word |
| dma_busy | input | 1 | A DMA transfer is running |
| pend_clear | input | 1 | Data-port write or status read seen |
| reg_q | output | NREG*8 | Register file, register i at bits 8i+7:8i |
| addr | output | 16 | Command address |
| cmd_code | output | 6 | Command code |
| pending | output | 1 | First half received, second awaited |
| dma_start | output | 1 | One-cycle launch of an immediate DMA |
| dma_copy | output | 1 | Launched DMA is a copy (else memory transfer) |
| dma_cmd | output | 6 | Command code latched at launch |
| fill_arm | output | 1 | One-cycle pulse: fill armed for data port |
| wr_reject | output | 1 | One-cycle pulse: write refused during DMA |

## Verification
The bench builds the block with its default parameters. These are 24 registers, mode register 1 with enable bit 4, and source-high register 23. The 5-bit register field can therefore name registers 24 to 31, which exercises the ignore path of R3. The sweep also writes the mode and source-high registers, so immediate launches, copies and armed fills all occur between command halves. Busy and clear inputs land on both halves of a command.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_REG    = 2'd1,
    WK_FIRST  = 2'd2,
    WK_SECOND = 2'd3
  } word_kind_e;

  typedef struct packed {
    word_kind_e  kind;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_val;
    logic [13:0] lo_addr;
    logic [1:0]  lo_cc;
    logic [1:0]  hi_addr;
    logic [3:0]  hi_cc;
  } word_dec_t;
endpackage

// File: rtl/ctlport_word_decode.sv
module ctlport_word_decode
  import ctlport_pkg::*;
(
  input  logic        wr_valid,
  input  logic        dma_busy,
  input  logic        pending,
  input  logic [15:0] wr_data,
  output word_dec_t   dec,
  output logic        refused
);
  always_comb begin
    dec         = '0;
    dec.reg_idx = wr_data[12:8];
    dec.reg_val = wr_data[7:0];
    dec.lo_addr = wr_data[13:0];
    dec.lo_cc   = wr_data[15:14];
    dec.hi_addr = wr_data[1:0];
    dec.hi_cc   = wr_data[7:4];
    refused     = wr_valid && dma_busy;
    if (wr_valid && !dma_busy) begin
      if (pending)                    dec.kind = WK_SECOND;
      else if (wr_data[15:14] == 2'b10) dec.kind = WK_REG;
      else                            dec.kind = WK_FIRST;
    end else begin
      dec.kind = WK_NONE;
    end
  end
endmodule

// File: rtl/ctlport_regfile.sv
module ctlport_regfile #(
  parameter int NREG  = 24,
  parameter int IDX_W = 5,
  localparam int QW   = NREG * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       val,
  output logic [QW-1:0]    q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic en;
    assign en = we && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i*8 +: 8] <= '0;
      else if (en) q[i*8 +: 8] <= val;
    end
  end
endmodule

// File: rtl/ctlport_cmd_state.sv
module ctlport_cmd_state
  import ctlport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  word_dec_t   dec,
  input  logic        refused,
  input  logic        pend_clear,
  input  logic        dma_en,
  input  logic [1:0]  src_mode,
  output logic [15:0] addr,
  output logic [5:0]  cmd_code,
  output logic        pending,
  output logic        dma_start,
  output logic        dma_copy,
  output logic [5:0]  dma_cmd,
  output logic        fill_arm,
  output logic        wr_reject
);
  logic [15:0] addr_d;
  logic [5:0]  cc_d, dcmd_d;
  logic        pend_d, start_d, copy_d, fill_d, dma_req;

  always_comb begin
    addr_d  = addr;
    cc_d    = cmd_code;
    pend_d  = pending;
    dcmd_d  = dma_cmd;
    copy_d  = dma_copy;
    start_d = 1'b0;
    fill_d  = 1'b0;
    dma_req = 1'b0;
    unique case (dec.kind)
      WK_FIRST: begin
        addr_d = {addr[15:14], dec.lo_addr};
        cc_d   = {cmd_code[5:2], dec.lo_cc};
        pend_d = 1'b1;
      end
      WK_SECOND: begin
        addr_d  = {dec.hi_addr, addr[13:0]};
        cc_d    = {dec.hi_cc, cmd_code[1:0]};
        pend_d  = 1'b0;
        dma_req = cc_d[5] && dma_en;
      end
      WK_REG: ;
      default: if (pend_clear) pend_d = 1'b0;
    endcase
    if (dma_req) begin
      if (src_mode != 2'b10) begin
        start_d = 1'b1;
        dcmd_d  = cc_d;
        copy_d  = src_mode[1];
      end else begin
        fill_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      cmd_code  <= '0;
      pending   <= 1'b0;
      dma_start <= 1'b0;
      dma_copy  <= 1'b0;
      dma_cmd   <= '0;
      fill_arm  <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      addr      <= addr_d;
      cmd_code  <= cc_d;
      pending   <= pend_d;
      dma_start <= start_d;
      dma_copy  <= copy_d;
      dma_cmd   <= dcmd_d;
      fill_arm  <= fill_d;
      wr_reject <= refused;
    end
  end
endmodule

// File: rtl/ctlport_decoder.sv
module ctlport_decoder
  import ctlport_pkg::*;
#(
  parameter int NREG       = 24,
  parameter int MODE_REG   = 1,
  parameter int DMA_EN_BIT = 4,
  parameter int SRC_HI_REG = 23,
  localparam int QW        = NREG * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [15:0]   wr_data,
  input  logic          dma_busy,
  input  logic          pend_clear,
  output logic [QW-1:0] reg_q,
  output logic [15:0]   addr,
  output logic [5:0]    cmd_code,
  output logic          pending,
  output logic          dma_start,
  output logic          dma_copy,
  output logic [5:0]    dma_cmd,
  output logic          fill_arm,
  output logic          wr_reject
);
  word_dec_t dec;
  logic      refused;
  logic      dma_en;
  logic [1:0] src_mode;

  ctlport_word_decode u_dec (
    .wr_valid (wr_valid),
    .dma_busy (dma_busy),
    .pending  (pending),
    .wr_data  (wr_data),
    .dec      (dec),
    .refused  (refused)
  );

  ctlport_regfile #(.NREG(NREG), .IDX_W(5)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dec.kind == WK_REG),
    .idx   (dec.reg_idx),
    .val   (dec.reg_val),
    .q     (reg_q)
  );

  assign dma_en   = reg_q[MODE_REG*8 + DMA_EN_BIT];
  assign src_mode = reg_q[SRC_HI_REG*8 + 6 +: 2];

  ctlport_cmd_state u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (dec),
    .refused    (refused),
    .pend_clear (pend_clear),
    .dma_en     (dma_en),
    .src_mode   (src_mode),
    .addr       (addr),
    .cmd_code   (cmd_code),
    .pending    (pending),
    .dma_start  (dma_start),
    .dma_copy   (dma_copy),
    .dma_cmd    (dma_cmd),
    .fill_arm   (fill_arm),
    .wr_reject  (wr_reject)
  );
endmodule

// File: rtl/ctlport_checker.sv
module ctlport_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [15:0] wr_data,
  input logic        dma_busy,
  input logic        pend_clear,
  input logic [15:0] addr,
  input logic [5:0]  cmd_code,
  input logic        pending,
  input logic        dma_start,
  input logic        fill_arm,
  input logic        wr_reject
);
  logic took;
  assign took = wr_valid && !dma_busy;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && dma_busy && !pend_clear |=> $stable(addr) && $stable(cmd_code) && $stable(pending) && !dma_start && !fill_arm); // R1
  AST_REG_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    took && !pending && wr_data[15:14] == 2'b10 |=> !pending); // R2
  AST_FIRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    took && !pending && wr_data[15:14] != 2'b10 |=> pending && addr[13:0] == $past(wr_data[13:0])); // R4
  AST_SECOND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    took && pending |=> !pending && cmd_code[5:2] == $past(wr_data[7:4])); // R5
  AST_START_NEEDS_B5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start || fill_arm |-> cmd_code[5]); // R6
  AST_START_XOR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_start && fill_arm)); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clear && !wr_valid |=> !pending); // R9
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && dma_busy |=> wr_reject); // R10
endmodule

bind ctlport_decoder ctlport_checker u_chk (.*);

// File: tb/tb_ctlport_decoder.sv
module tb_ctlport_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic dma_busy = 1'b0;
  logic pend_clear = 1'b0;
  logic [NREG*8-1:0] reg_q;
  logic [15:0] addr;
  logic [5:0] cmd_code, dma_cmd;
  logic pending, dma_start, dma_copy, fill_arm, wr_reject;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_regs[NREG];
  int m_addr, m_cc, m_dcmd;
  bit m_pend, m_start, m_copy, m_fill, m_rej;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlport_decoder dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rq(input int i);
    return int'(reg_q[i*8 +: 8]);
  endfunction

  task automatic model_step(input bit v, input int wd, input bit busy, input bit pc);
    m_start = 0; m_fill = 0; m_rej = 0;
    if (v && busy) begin
      m_rej = 1;
      if (pc) m_pend = 0;
    end else if (v) begin
      if (!m_pend) begin
        if (((wd >> 14) & 3) == 2) begin
          if (((wd >> 8) & 31) < NREG) m_regs[(wd >> 8) & 31] = wd & 255;
        end else begin
          m_addr = (m_addr & 'hC000) | (wd & 'h3FFF);
          m_cc = (m_cc & 'h3C) | ((wd >> 14) & 3);
          m_pend = 1;
        end
      end else begin
        m_addr = (m_addr & 'h3FFF) | ((wd & 3) << 14);
        m_cc = (m_cc & 3) | (((wd >> 4) & 15) << 2);
        m_pend = 0;
        if ((m_cc & 'h20) && (m_regs[1] & 'h10)) begin
          if (((m_regs[23] >> 6) & 3) != 2) begin
            m_start = 1; m_dcmd = m_cc; m_copy = (m_regs[23] >> 7) & 1;
          end else m_fill = 1;
        end
      end
    end else if (pc) m_pend = 0;
  endtask

  task automatic compare_all();
    bit ok = 1;
    for (int i = 0; i < NREG; i++) if (rq(i) != m_regs[i]) ok = 0;
    chk(ok, "R2 regfile", 0, 0);
    chk(int'(addr) == m_addr && int'(cmd_code) == m_cc, "R5 addr/cc",
        {addr, 2'b0, cmd_code}, (m_addr << 8) | m_cc);
    chk(pending == m_pend, "R4 pending", pending, m_pend);
    chk(dma_start == m_start && (!m_start || (int'(dma_cmd) == m_dcmd && dma_copy == m_copy)),
        "R7 start", {dma_start, dma_copy, dma_cmd}, {m_start, m_copy, m_dcmd[5:0]});
    chk(fill_arm == m_fill, "R8 fill", fill_arm, m_fill);
    chk(wr_reject == m_rej, "R10 reject", wr_reject, m_rej);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input int wd, input bit busy, input bit pc);
    wr_valid = v; wr_data = wd[15:0]; dma_busy = busy; pend_clear = pc;
    @(posedge clk);
    model_step(v, wd, busy, pc);
    @(negedge clk);
    wr_valid = 0; dma_busy = 0; pend_clear = 0;
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "WATCHDOG", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int r0;
    for (int i = 0; i < NREG; i++) m_regs[i] = 0;
    m_addr = 0; m_cc = 0; m_dcmd = 0; m_pend = 0; m_start = 0; m_copy = 0; m_fill = 0; m_rej = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all(); // reset state
    chk(pending == 0 && addr == 0 && !dma_start, "RESET", pending, 0);

    step(1, 'h8255, 0, 0);                          // R2 reg 2 <- 55
    chk(rq(2) == 'h55 && !pending, "R2", rq(2), 'h55);
    r0 = rq(0);
    step(1, 'h9A77, 0, 0);                          // R3 reg 26 ignored
    chk(rq(0) == r0 && rq(2) == 'h55, "R3", rq(2), 'h55);
    step(1, 'h4123, 0, 0);                          // R4 first half
    chk(pending && addr[13:0] == 'h0123 && cmd_code[1:0] == 1, "R4", addr, 'h0123);
    step(1, 'h00A2, 0, 0);                          // R5/R6 no enable
    chk(!pending && addr == 'h8123 && cmd_code == 'h29 && !dma_start, "R6", cmd_code, 'h29);
    step(1, 'h8114, 0, 0);                          // enable DMA
    step(1, 'h9700, 0, 0);                          // source mode 00: memory
    step(1, 'h4010, 0, 0);
    step(1, 'h0081, 0, 0);
    chk(dma_start && !dma_copy && dma_cmd == 'h21, "R7", dma_cmd, 'h21);
    step(0, 0, 0, 0);
    chk(!dma_start, "R7 pulse", dma_start, 0);
    step(1, 'h97C0, 0, 0);                          // copy
    step(1, 'h0000, 0, 0);
    step(1, 'h00B0, 0, 0);
    chk(dma_start && dma_copy && dma_cmd == 'h2C, "R7 copy", dma_cmd, 'h2C);
    step(1, 'h9780, 0, 0);                          // fill mode
    step(1, 'h4000, 0, 0);
    step(1, 'h0080, 0, 0);
    chk(fill_arm && !dma_start, "R8", fill_arm, 1);
    step(1, 'h4555, 0, 0);
    step(1, 'h00F3, 1, 0);                          // R1 refused while pending
    chk(pending && wr_reject && addr[15:14] == 0, "R1", addr, 'h0555);
    chk(wr_reject, "R10", wr_reject, 1);
    step(0, 0, 0, 1);                               // R9 clear
    chk(!pending, "R9", pending, 0);
    step(1, 'h8000, 1, 0);
    chk(rq(0) == r0, "R1 reg", rq(0), r0);

    for (int n = 0; n < 4000; n++) begin
      int w, sel;
      sel = $urandom_range(0, 9);
      w = $urandom_range(0, 'hFFFF);
      if (sel == 0) w = 'h8100 | ($urandom_range(0, 1) << 4);
      if (sel == 1) w = 'h9700 | ($urandom_range(0, 3) << 6);
      if (sel == 2) w = w | 'h80;
      step($urandom_range(0, 3) != 0, w, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule